// File: doc/BRIEF.md
# Receive Frame Statistics Classifier

This block sits behind an Ethernet receive path and keeps frame statistics. When a frame ends, the receiver gives the block one status strobe. The strobe carries the byte length of the frame and five flags: a bit-remainder (dribble) flag, a bad-CRC flag, a flag that the PHY signalled a receive error, a flag that the address filter accepted the frame, and a flag that a receive buffer was free. In the same clock edge the block sorts the frame into every category that applies and advances the matching counters.

Frames fall into three length bands: shorter than 64 bytes, 64 to 1518 bytes, and longer than 1518 bytes. Within each band the error flags choose the category. A receive error on an accepted frame takes priority over everything else, and no other counter moves for that frame. Oversize and undersize frames are counted separately according to whether they carry an error.

Software reads the counters through a simple read port. Each read returns the count held before the read and clears that counter. A counter that reaches all ones stays there until it is read.

Top module: `rx_frame_stats`

## Requirements
- R1: A frame with `fe_addr_hit`=1, length from 64 to 1518, `fe_crc_bad`=0 and `fe_rxer`=0 increments the 24-bit good-frame counter at read address 0.
- R2: A frame with `fe_addr_hit`=1, length from 64 to 1518, `fe_rxer`=0, `fe_crc_bad`=1 and `fe_dribble`=0 increments the 8-bit FCS-error counter at read address 1.
- R3: A frame with `fe_addr_hit`=1, length from 64 to 1518, `fe_rxer`=0, `fe_crc_bad`=1 and `fe_dribble`=1 increments the 8-bit alignment-error counter at read address 2. A dribble frame whose CRC is good is counted as good under R1.
- R4: A frame with `fe_addr_hit`=1 and `fe_rxer`=1 increments only the 8-bit code-error counter at read address 3. No other counter moves, whatever the frame's length or other flags.
- R5: A frame longer than 1518 bytes with `fe_crc_bad`=0 and `fe_rxer`=0 increments the 8-bit oversize counter at read address 4. The address flag does not affect this counter.
- R6: A frame longer than 1518 bytes with `fe_crc_bad`=1 or `fe_rxer`=1 increments the 8-bit jabber counter at read address 5. R4 still applies when the address filter accepted the frame.
- R7: A frame shorter than 64 bytes with `fe_crc_bad`=0 and `fe_rxer`=0 increments the 8-bit undersize counter at read address 6. A short frame that has an error is not counted.
- R8: A frame with `fe_addr_hit`=1, `fe_buf_avail`=0 and `fe_rxer`=0 increments the 16-bit discard counter at read address 7. This is in addition to its other category.
- R9: A counter that holds all ones stays at all ones when more increments arrive.
- R10: `rd_en`=1 with a mapped `rd_addr` puts the counter's value before the read, zero-extended, on `rd_data` one cycle later, and clears that counter. `rd_data` keeps its value while `rd_en`=0.
- R11: A read at addresses 8 to 15 returns zero and clears no counter.
- R12: When an increment and a clearing read of the same counter happen in the same cycle, the read returns the old value and the counter is left at 1.
- R13: A frame with `fe_addr_hit`=0 changes none of the counters at addresses 0, 1, 2, 3 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fe_valid | input | 1 | End-of-frame status strobe, one cycle per frame |
| fe_len | input | 16 | Frame length in whole bytes |
| fe_dribble | input | 1 | Frame had extra bits beyond a whole byte |
| fe_crc_bad | input | 1 | CRC check failed (after truncation to whole bytes) |
| fe_rxer | input | 1 | PHY receive error seen during the frame |
| fe_addr_hit | input | 1 | Address filter accepted the frame |
| fe_buf_avail | input | 1 | A receive buffer was available for the frame |
| rd_en | input | 1 | Read strobe; clears the addressed counter |
| rd_addr | input | 4 | Counter select |
| rd_data | output | 32 | Value read, valid the cycle after `rd_en` |

## Verification
The counters can only be seen through reads, so a wrong internal count stays hidden until the affected counter is read. When that read happens, the error shows up one cycle later as a wrong `rd_data` value. A bad clear is seen on the next read of the same counter. The bench therefore reads often and at random addresses, including unmapped ones, so that a misclassified frame, a counter that wraps instead of sticking, or a clear that hits the wrong counter shows up within a few dozen cycles. Each cycle is compared against a behavioural model.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int NUM_CNT = 8;

    typedef enum logic [2:0] {
        CNT_GOOD    = 3'd0,
        CNT_FCS     = 3'd1,
        CNT_ALIGN   = 3'd2,
        CNT_CODE    = 3'd3,
        CNT_LONG    = 3'd4,
        CNT_JABBER  = 3'd5,
        CNT_SHORT   = 3'd6,
        CNT_DISCARD = 3'd7
    } cnt_sel_e;

    typedef struct packed {
        logic dribble;
        logic crc_bad;
        logic rxer;
        logic addr_hit;
        logic buf_avail;
    } frame_flags_t;

    typedef struct packed {
        logic in_short;
        logic in_mid;
        logic in_long;
        logic code_err;
        logic any_err;
    } frame_class_t;

endpackage

// File: rtl/rxs_classifier.sv
module rxs_classifier
    import rxs_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 1518
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [LEN_W-1:0]   len,
    input  frame_flags_t       flags,
    output logic [NUM_CNT-1:0] bump
);

    localparam logic [LEN_W-1:0] LO_LEN = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] HI_LEN = LEN_W'(MAX_LEN);

    frame_class_t cls;

    always_comb begin
        cls.in_short = (len < LO_LEN);
        cls.in_long  = (len > HI_LEN);
        cls.in_mid   = !cls.in_short && !cls.in_long;
        cls.code_err = flags.addr_hit && flags.rxer;
        cls.any_err  = flags.crc_bad || flags.rxer;
    end

    always_comb begin
        bump = '0;
        if (valid) begin
            if (cls.code_err) begin
                bump[CNT_CODE] = 1'b1;
            end else begin
                if (flags.addr_hit && cls.in_mid) begin
                    if (!flags.crc_bad)
                        bump[CNT_GOOD] = 1'b1;
                    else if (flags.dribble)
                        bump[CNT_ALIGN] = 1'b1;
                    else
                        bump[CNT_FCS] = 1'b1;
                end
                if (cls.in_long) begin
                    if (cls.any_err)
                        bump[CNT_JABBER] = 1'b1;
                    else
                        bump[CNT_LONG] = 1'b1;
                end
                if (cls.in_short && !cls.any_err)
                    bump[CNT_SHORT] = 1'b1;
                if (flags.addr_hit && !flags.buf_avail)
                    bump[CNT_DISCARD] = 1'b1;
            end
        end
    end

    // R4: a code error moves only its own counter
    assert_code_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && flags.addr_hit && flags.rxer) |-> (bump == (NUM_CNT'(1) << CNT_CODE)));

    // R13: a frame the address filter rejected leaves the address-qualified counters alone
    assert_no_addr_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !flags.addr_hit) |-> (!bump[CNT_GOOD] && !bump[CNT_FCS] && !bump[CNT_ALIGN]
                                        && !bump[CNT_CODE] && !bump[CNT_DISCARD]));

    // R1: no increments without a status strobe
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (bump == '0));

    // R2: the three mid-band categories never fire together
    assert_mid_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bump[CNT_GOOD], bump[CNT_FCS], bump[CNT_ALIGN]}));

endmodule

// File: rtl/rxs_sat_counter.sv
module rxs_sat_counter #(
    parameter int W     = 8,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [OUT_W-1:0] value
);

    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)
            st_d.count = inc ? W'(1) : '0;
        else if (inc && (st_q.count != {W{1'b1}}))
            st_d.count = st_q.count + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = OUT_W'(st_q.count);

    // R9: a saturated counter sticks until cleared
    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (st_q.count == {W{1'b1}})) |=> (st_q.count == {W{1'b1}}));

    // R10: a clearing read with no increment leaves zero
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (st_q.count == '0));

    // R12: increment during a clear leaves one
    assert_clear_inc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (st_q.count == W'(1)));

    // R1: an unsaturated counter steps by exactly one
    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && (st_q.count != {W{1'b1}})) |=> (st_q.count == $past(st_q.count) + W'(1)));

endmodule

// File: rtl/rxs_read_port.sv
module rxs_read_port #(
    parameter int NUM = 8,
    parameter int DW  = 32,
    parameter int AW  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic [AW-1:0]          rd_addr,
    input  logic [NUM-1:0][DW-1:0] values,
    output logic [NUM-1:0]         clr,
    output logic [DW-1:0]          rd_data
);

    typedef struct packed {
        logic [DW-1:0] data;
    } rd_state_t;

    rd_state_t rs_d, rs_q;
    logic      mapped;

    always_comb begin
        mapped = (int'(rd_addr) < NUM);
        clr    = '0;
        rs_d   = rs_q;
        if (rd_en) begin
            rs_d.data = '0;
            for (int i = 0; i < NUM; i++) begin
                if (int'(rd_addr) == i) begin
                    clr[i]    = 1'b1;
                    rs_d.data = values[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_data = rs_q.data;

    // R11: unmapped read returns zero and clears nothing
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rd_data == '0));
    assert_unmapped_noclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |-> (clr == '0));

    // R10: at most one counter cleared per cycle, and read data holds when idle
    assert_one_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/rx_frame_stats.sv
module rx_frame_stats
    import rxs_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = 64,
    parameter int MAX_LEN    = 1518,
    parameter int GOOD_W     = 24,
    parameter int ERR_W      = 8,
    parameter int DISCARD_W  = 16,
    parameter int RD_AW      = 4,
    parameter int RD_DW      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fe_valid,
    input  logic [LEN_W-1:0] fe_len,
    input  logic             fe_dribble,
    input  logic             fe_crc_bad,
    input  logic             fe_rxer,
    input  logic             fe_addr_hit,
    input  logic             fe_buf_avail,
    input  logic             rd_en,
    input  logic [RD_AW-1:0] rd_addr,
    output logic [RD_DW-1:0] rd_data
);

    frame_flags_t                  flags;
    logic [NUM_CNT-1:0]            bump;
    logic [NUM_CNT-1:0]            clr;
    logic [NUM_CNT-1:0][RD_DW-1:0] values;

    assign flags = '{dribble:   fe_dribble,
                     crc_bad:   fe_crc_bad,
                     rxer:      fe_rxer,
                     addr_hit:  fe_addr_hit,
                     buf_avail: fe_buf_avail};

    rxs_classifier #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN)
    ) i_classifier (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (fe_valid),
        .len   (fe_len),
        .flags (flags),
        .bump  (bump)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam int CW = (g == int'(CNT_GOOD))    ? GOOD_W :
                            (g == int'(CNT_DISCARD)) ? DISCARD_W : ERR_W;
        rxs_sat_counter #(
            .W     (CW),
            .OUT_W (RD_DW)
        ) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (bump[g]),
            .clr   (clr[g]),
            .value (values[g])
        );
    end

    rxs_read_port #(
        .NUM (NUM_CNT),
        .DW  (RD_DW),
        .AW  (RD_AW)
    ) i_read_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .values  (values),
        .clr     (clr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_rx_frame_stats.sv
module test_rx_frame_stats;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fe_valid = 1'b0;
    logic [15:0] fe_len = '0;
    logic        fe_dribble = 1'b0, fe_crc_bad = 1'b0, fe_rxer = 1'b0;
    logic        fe_addr_hit = 1'b0, fe_buf_avail = 1'b1;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;

    always #2 clk = ~clk;

    rx_frame_stats i_rx_frame_stats (
        .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_len(fe_len),
        .fe_dribble(fe_dribble), .fe_crc_bad(fe_crc_bad), .fe_rxer(fe_rxer),
        .fe_addr_hit(fe_addr_hit), .fe_buf_avail(fe_buf_avail),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int    n_cmp = 0, n_bad = 0;
    bit    done = 1'b0;
    string tag = "R10";
    longint cnt  [8];
    longint maxv [8] = '{24'hFFFFFF, 255, 255, 255, 255, 255, 255, 16'hFFFF};
    longint exp_rd = 0;

    task automatic compare();
        n_cmp++;
        if (longint'(rd_data) != exp_rd) begin
            n_bad++;
            $display("FAIL %s: rd_data actual %0d expected %0d at %0t", tag, rd_data, exp_rd, $time);
        end
    endtask

    // One clock: inputs are applied at the falling edge, the model follows the rising edge,
    // and the output is compared at the next falling edge.
    task automatic cyc(input bit v, input int len, input bit dr, input bit crc, input bit rx,
                       input bit ah, input bit ba, input bit re, input int ra);
        bit inc [8];
        fe_valid = v; fe_len = 16'(len); fe_dribble = dr; fe_crc_bad = crc; fe_rxer = rx;
        fe_addr_hit = ah; fe_buf_avail = ba; rd_en = re; rd_addr = 4'(ra);
        @(posedge clk);
        foreach (inc[i]) inc[i] = 1'b0;
        if (v) begin
            if (ah && rx) inc[3] = 1'b1;
            else begin
                if (ah && len >= 64 && len <= 1518) begin
                    if (!crc) inc[0] = 1'b1;
                    else if (dr) inc[2] = 1'b1;
                    else inc[1] = 1'b1;
                end
                if (len > 1518) begin
                    if (crc || rx) inc[5] = 1'b1; else inc[4] = 1'b1;
                end
                if (len < 64 && !crc && !rx) inc[6] = 1'b1;
                if (ah && !ba) inc[7] = 1'b1;
            end
        end
        if (re) exp_rd = (ra < 8) ? cnt[ra] : 0;
        for (int i = 0; i < 8; i++) begin
            if (re && ra == i) cnt[i] = inc[i] ? 1 : 0;
            else if (inc[i] && cnt[i] < maxv[i]) cnt[i]++;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic frame(input int len, input bit dr, input bit crc, input bit rx,
                         input bit ah, input bit ba);
        cyc(1, len, dr, crc, rx, ah, ba, 0, 0);
    endtask

    task automatic rd(input int ra);
        cyc(0, 0, 0, 0, 0, 0, 1, 1, ra);
    endtask

    task automatic read_all();
        for (int a = 0; a < 8; a++) rd(a);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        foreach (cnt[i]) cnt[i] = 0;
        repeat (3) @(negedge clk);
        tag = "R10"; compare();              // reset state
        rst_n = 1'b1;
        @(negedge clk);
        read_all();

        tag = "R1";  frame(64, 0, 0, 0, 1, 1); frame(1518, 0, 0, 0, 1, 1); frame(500, 1, 0, 0, 1, 1); rd(0);
        tag = "R2";  frame(64, 0, 1, 0, 1, 1); frame(1518, 0, 1, 0, 1, 1); rd(1);
        tag = "R3";  frame(100, 1, 1, 0, 1, 1); rd(2); rd(1);
        tag = "R4";  frame(2000, 1, 1, 1, 1, 0); frame(30, 0, 0, 1, 1, 0); frame(700, 0, 0, 1, 1, 1); read_all();
        tag = "R5";  frame(1519, 0, 0, 0, 1, 1); frame(4000, 0, 0, 0, 0, 1); rd(4); rd(0);
        tag = "R6";  frame(1519, 0, 1, 0, 1, 1); frame(1600, 0, 0, 1, 0, 1); rd(5); rd(3);
        tag = "R7";  frame(63, 0, 0, 0, 0, 1); frame(10, 0, 1, 0, 1, 1); frame(63, 0, 0, 1, 0, 1); rd(6);
        tag = "R8";  frame(200, 0, 0, 0, 1, 0); frame(20, 0, 1, 0, 1, 0); rd(7); rd(0);
        tag = "R13"; frame(300, 0, 1, 0, 0, 0); frame(300, 0, 0, 0, 0, 0); read_all();
        tag = "R11"; frame(400, 0, 0, 0, 1, 1); rd(8); rd(15); rd(0); rd(0);
        tag = "R12"; frame(800, 0, 0, 0, 1, 1); frame(800, 0, 0, 0, 1, 1);
        cyc(1, 800, 0, 0, 0, 1, 1, 1, 0); rd(0);
        tag = "R9";
        for (int k = 0; k < 300; k++) frame(40, 0, 0, 0, 1, 1);
        rd(6); rd(6);
        for (int k = 0; k < 260; k++) frame(1000, 0, 1, 0, 1, 1);
        cyc(1, 1000, 0, 1, 0, 1, 1, 1, 1); rd(1);

        tag = "R10";
        for (int k = 0; k < 20000; k++) begin
            int lens [8] = '{10, 63, 64, 65, 900, 1518, 1519, 3000};
            cyc($urandom_range(0, 3) != 0, lens[$urandom_range(0, 7)],
                $urandom_range(0, 1), $urandom_range(0, 2) == 0, $urandom_range(0, 7) == 0,
                $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
                $urandom_range(0, 4) == 0, $urandom_range(0, 11));
        end
        read_all();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule